// File: doc/BRIEF.md
# Ethernet MAC control and interrupt register slice

This block is the control and interrupt register slice of an Ethernet MAC, reached over a simple 32-bit word-addressed register bus. It holds three registers. The control register carries a module enable, a pin-routing enable and a self-clearing local reset. The event register records conditions that the MAC raises internally. The mask register selects which recorded events drive the single interrupt output.

Internal MAC logic reports each condition with a one-cycle pulse on its own input line. The pulse always sets the matching event bit, whatever the mask holds. Software clears an event bit by writing a one to its position.

The block exports the module enable level. It also exports a one-cycle pointer-reset pulse that returns the DMA, descriptor and FIFO pointer logic to its start whenever the enable falls. Writing the local reset bit clears every register and holds the slice in reset for a fixed number of cycles. During that time, register writes and event pulses have no effect.

Top module: `eth_ctl_irq_regs`

## Requirements
- R1: The control register is at word address 0. The module enable is bit [1] and the pin-routing enable is bit [2]; both can be read and written, and they drive `en_o` and `pinmux_o`. Bits [31:3] always read zero, and writing them has no effect. After reset, the control register reads zero.
- R2: `irq_o` is high exactly while at least one event bit and the mask bit at the same position are both set. It changes on the same clock edge as the event or mask register. The mask register is at word address 2 and uses the same bit positions as the event register.
- R3: The event register is at word address 1. A pulse on `evt_pulse[k]` sets word bit 31-k, even if the mask bit at that position is zero. Bits [21:0] always read zero.
- R4: Writing to the event register clears every bit written as 1. Every bit written as 0 keeps its value.
- R5: If an event pulse and a write-1-to-clear reach the same bit in the same cycle, the bit ends up set.
- R6: Writing 1 to control bit [0] starts a local reset. The enable, the pin-routing enable, the event register and the mask register all return to zero. Control bit [0] reads 1 for exactly RST_CYCLES (default 16) cycles and then reads 0.
- R7: While the local reset is running, writes to any register are ignored.
- R8: Each time `en_o` falls, whether by a register write or by a local reset, `ptr_rst_o` is high for exactly one cycle, starting on the same edge. It stays low at all other times, including when a write leaves the enable at zero.
- R9: Event pulses that arrive while the local reset is running are not recorded.
- R10: Read data appears on `bus_rdata` one cycle after the address is presented. Unmapped addresses read zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_we | input | 1 | Write strobe for the addressed register |
| bus_addr | input | ADDR_W (4) | Word address |
| bus_wdata | input | DATA_W (32) | Write data |
| bus_rdata | output | DATA_W (32) | Registered read data for the previous cycle's address |
| evt_pulse | input | NUM_EVT (10) | One-cycle event strobes from the MAC; index k maps to word bit 31-k |
| irq_o | output | 1 | Interrupt request |
| en_o | output | 1 | Module enable |
| pinmux_o | output | 1 | Pin-routing enable |
| ptr_rst_o | output | 1 | One-cycle reset pulse for the DMA, descriptor and FIFO pointers |

## Verification
The bench drives an event pulse and a clear of the same bit in one cycle. A design that gives the clear priority would lose the event, and the bit would read back as zero. The bench counts, one cycle at a time, how long the local reset bit reads as 1. It then checks that writes and event pulses made inside that window leave no trace. An off-by-one counter, or a register not tied to the reset window, would give a wrong count or leave stale bits. The bench also checks the pointer-reset pulse in three cases: when a write clears the enable, when the local reset clears it, and when a write leaves the enable at zero. A design that decodes the write instead of the falling edge would pulse in the wrong case or miss a real fall.

// File: rtl/eth_ctl_pkg.sv
package eth_ctl_pkg;
  // word addresses of the three registers
  localparam int unsigned CTRL_WORD = 0;
  localparam int unsigned EVT_WORD  = 1;
  localparam int unsigned MASK_WORD = 2;

  // control register bit positions
  localparam int unsigned CTRL_LRST_BIT = 0;
  localparam int unsigned CTRL_EN_BIT   = 1;
  localparam int unsigned CTRL_PMX_BIT  = 2;

  typedef enum logic [1:0] {
    SEL_CTRL,
    SEL_EVT,
    SEL_MASK,
    SEL_NONE
  } reg_sel_e;
endpackage

// File: rtl/eth_ctl_lrst.sv
module eth_ctl_lrst #(
  parameter int unsigned RST_CYCLES = 16,
  localparam int unsigned CNT_W = (RST_CYCLES > 1) ? $clog2(RST_CYCLES) : 1
) (
  input  logic clk,
  input  logic rst,
  input  logic wr_ctl,
  input  logic wd_lrst,
  input  logic wd_en,
  input  logic wd_pmx,
  output logic busy_o,
  output logic en_o,
  output logic pmx_o,
  output logic ptr_rst_o
);
  logic             busy_q;
  logic [CNT_W-1:0] cnt_q;
  logic             en_q, pmx_q, ptr_q;
  logic             en_nxt, pmx_nxt, start;

  always_comb begin
    en_nxt  = en_q;
    pmx_nxt = pmx_q;
    start   = 1'b0;
    if (busy_q) begin
      en_nxt  = 1'b0;
      pmx_nxt = 1'b0;
    end else if (wr_ctl) begin
      if (wd_lrst) begin
        start   = 1'b1;
        en_nxt  = 1'b0;
        pmx_nxt = 1'b0;
      end else begin
        en_nxt  = wd_en;
        pmx_nxt = wd_pmx;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      busy_q <= 1'b0;
      cnt_q  <= '0;
      en_q   <= 1'b0;
      pmx_q  <= 1'b0;
      ptr_q  <= 1'b0;
    end else begin
      en_q  <= en_nxt;
      pmx_q <= pmx_nxt;
      ptr_q <= en_q & ~en_nxt;
      if (start) begin
        busy_q <= 1'b1;
        cnt_q  <= CNT_W'(RST_CYCLES - 1);
      end else if (busy_q) begin
        if (cnt_q == '0) busy_q <= 1'b0;
        else             cnt_q  <= cnt_q - 1'b1;
      end
    end
  end

  assign busy_o    = busy_q;
  assign en_o      = en_q;
  assign pmx_o     = pmx_q;
  assign ptr_rst_o = ptr_q;

  assert_lrst_holds_R6: assert property (@(posedge clk) disable iff (rst)
    (busy_q && cnt_q != '0) |=> busy_q);
  assert_lrst_loads_R6: assert property (@(posedge clk) disable iff (rst)
    start |=> (busy_q && cnt_q == CNT_W'(RST_CYCLES - 1)));
  assert_lrst_clears_en_R6: assert property (@(posedge clk) disable iff (rst)
    busy_q |-> (!en_q && !pmx_q));
  assert_busy_ignores_wr_R7: assert property (@(posedge clk) disable iff (rst)
    (busy_q && wr_ctl && wd_en) |=> !en_q);
  assert_ptr_on_fall_R8: assert property (@(posedge clk) disable iff (rst)
    $fell(en_q) |-> ptr_q);
  assert_ptr_only_fall_R8: assert property (@(posedge clk) disable iff (rst)
    ptr_q |-> $fell(en_q));
endmodule

// File: rtl/eth_evt_irq.sv
module eth_evt_irq #(
  parameter int unsigned NUM_EVT = 10
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               clr_all,
  input  logic [NUM_EVT-1:0] evt_pulse,
  input  logic               wr_evt,
  input  logic               wr_mask,
  input  logic [NUM_EVT-1:0] wfield,
  output logic [NUM_EVT-1:0] evt_o,
  output logic [NUM_EVT-1:0] mask_o,
  output logic               irq_o
);
  logic [NUM_EVT-1:0] evt_q, mask_q, evt_nxt, mask_nxt;
  logic               irq_q;

  for (genvar k = 0; k < NUM_EVT; k++) begin : g_bit
    always_comb begin
      if (clr_all) begin
        evt_nxt[k]  = 1'b0;
        mask_nxt[k] = 1'b0;
      end else begin
        evt_nxt[k]  = evt_pulse[k] | (evt_q[k] & ~(wr_evt & wfield[k]));
        mask_nxt[k] = wr_mask ? wfield[k] : mask_q[k];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      evt_q  <= '0;
      mask_q <= '0;
      irq_q  <= 1'b0;
    end else begin
      evt_q  <= evt_nxt;
      mask_q <= mask_nxt;
      irq_q  <= |(evt_nxt & mask_nxt);
    end
  end

  assign evt_o  = evt_q;
  assign mask_o = mask_q;
  assign irq_o  = irq_q;

  assert_irq_tracks_R2: assert property (@(posedge clk) disable iff (rst)
    irq_q == |(evt_q & mask_q));
  assert_pulse_sets_R3: assert property (@(posedge clk) disable iff (rst)
    (!clr_all && evt_pulse != '0) |=> ((evt_q & $past(evt_pulse)) == $past(evt_pulse)));
  assert_w1c_clears_R4: assert property (@(posedge clk) disable iff (rst)
    (!clr_all && wr_evt) |=> ((evt_q & $past(wfield & ~evt_pulse)) == '0));
  assert_set_wins_R5: assert property (@(posedge clk) disable iff (rst)
    (!clr_all && wr_evt && (wfield & evt_pulse) != '0)
      |=> ((evt_q & $past(wfield & evt_pulse)) == $past(wfield & evt_pulse)));
  assert_lrst_drops_evt_R9: assert property (@(posedge clk) disable iff (rst)
    clr_all |=> (evt_q == '0 && mask_q == '0));
endmodule

// File: rtl/eth_rd_mux.sv
module eth_rd_mux
  import eth_ctl_pkg::*;
#(
  parameter int unsigned DATA_W  = 32,
  parameter int unsigned NUM_EVT = 10
) (
  input  logic               clk,
  input  logic               rst,
  input  reg_sel_e           sel,
  input  logic               busy,
  input  logic               en,
  input  logic               pmx,
  input  logic [NUM_EVT-1:0] evt,
  input  logic [NUM_EVT-1:0] mask,
  output logic [DATA_W-1:0]  rdata
);
  logic [DATA_W-1:0] ctrl_w, evt_w, mask_w, rd_q;

  always_comb begin
    ctrl_w                = '0;
    ctrl_w[CTRL_LRST_BIT] = busy;
    ctrl_w[CTRL_EN_BIT]   = en;
    ctrl_w[CTRL_PMX_BIT]  = pmx;
  end

  // event k sits at word bit DATA_W-1-k
  for (genvar b = 0; b < DATA_W; b++) begin : g_map
    if (b >= DATA_W - NUM_EVT) begin : g_def
      assign evt_w[b]  = evt[DATA_W-1-b];
      assign mask_w[b] = mask[DATA_W-1-b];
    end else begin : g_rsv
      assign evt_w[b]  = 1'b0;
      assign mask_w[b] = 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) rd_q <= '0;
    else begin
      unique case (sel)
        SEL_CTRL: rd_q <= ctrl_w;
        SEL_EVT:  rd_q <= evt_w;
        SEL_MASK: rd_q <= mask_w;
        default:  rd_q <= '0;
      endcase
    end
  end

  assign rdata = rd_q;

  assert_rsv_zero_R1: assert property (@(posedge clk) disable iff (rst)
    (sel == SEL_CTRL) |=> (rd_q[DATA_W-1:3] == '0));
endmodule

// File: rtl/eth_ctl_irq_regs.sv
module eth_ctl_irq_regs
  import eth_ctl_pkg::*;
#(
  parameter int unsigned DATA_W     = 32,
  parameter int unsigned ADDR_W     = 4,
  parameter int unsigned NUM_EVT    = 10,
  parameter int unsigned RST_CYCLES = 16
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               bus_we,
  input  logic [ADDR_W-1:0]  bus_addr,
  input  logic [DATA_W-1:0]  bus_wdata,
  output logic [DATA_W-1:0]  bus_rdata,
  input  logic [NUM_EVT-1:0] evt_pulse,
  output logic               irq_o,
  output logic               en_o,
  output logic               pinmux_o,
  output logic               ptr_rst_o
);
  reg_sel_e           sel;
  logic               busy;
  logic [NUM_EVT-1:0] wfield, evt, mask;

  always_comb begin
    if (bus_addr == ADDR_W'(CTRL_WORD))      sel = SEL_CTRL;
    else if (bus_addr == ADDR_W'(EVT_WORD))  sel = SEL_EVT;
    else if (bus_addr == ADDR_W'(MASK_WORD)) sel = SEL_MASK;
    else                                     sel = SEL_NONE;
  end

  for (genvar k = 0; k < NUM_EVT; k++) begin : g_wf
    assign wfield[k] = bus_wdata[DATA_W-1-k];
  end

  eth_ctl_lrst #(.RST_CYCLES(RST_CYCLES)) u_ctl (
    .clk       (clk),
    .rst       (rst),
    .wr_ctl    (bus_we && sel == SEL_CTRL),
    .wd_lrst   (bus_wdata[CTRL_LRST_BIT]),
    .wd_en     (bus_wdata[CTRL_EN_BIT]),
    .wd_pmx    (bus_wdata[CTRL_PMX_BIT]),
    .busy_o    (busy),
    .en_o      (en_o),
    .pmx_o     (pinmux_o),
    .ptr_rst_o (ptr_rst_o)
  );

  eth_evt_irq #(.NUM_EVT(NUM_EVT)) u_evt (
    .clk       (clk),
    .rst       (rst),
    .clr_all   (busy),
    .evt_pulse (evt_pulse),
    .wr_evt    (bus_we && sel == SEL_EVT),
    .wr_mask   (bus_we && sel == SEL_MASK),
    .wfield    (wfield),
    .evt_o     (evt),
    .mask_o    (mask),
    .irq_o     (irq_o)
  );

  eth_rd_mux #(.DATA_W(DATA_W), .NUM_EVT(NUM_EVT)) u_rd (
    .clk   (clk),
    .rst   (rst),
    .sel   (sel),
    .busy  (busy),
    .en    (en_o),
    .pmx   (pinmux_o),
    .evt   (evt),
    .mask  (mask),
    .rdata (bus_rdata)
  );

  assert_unmapped_zero_R10: assert property (@(posedge clk) disable iff (rst)
    (sel == SEL_NONE) |=> (bus_rdata == '0));
endmodule

// File: tb/eth_ctl_irq_regs_tb.sv
module eth_ctl_irq_regs_tb;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        bus_we = 1'b0;
  logic [3:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic [9:0]  evt_pulse = '0;
  logic        irq_o, en_o, pinmux_o, ptr_rst_o;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  always #4 clk = ~clk;

  eth_ctl_irq_regs u_dut (
    .clk(clk), .rst(rst), .bus_we(bus_we), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .evt_pulse(evt_pulse),
    .irq_o(irq_o), .en_o(en_o), .pinmux_o(pinmux_o), .ptr_rst_o(ptr_rst_o)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_we = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_we = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_addr = a;
    @(negedge clk);
    d = bus_rdata;
  endtask

  task automatic pulse(input logic [9:0] p);
    @(negedge clk);
    evt_pulse = p;
    @(negedge clk);
    evt_pulse = '0;
  endtask

  task automatic t_reset_state;
    logic [31:0] d;
    rd(4'd0, d); chk("R1 ctrl after reset", d, 32'h0);
    rd(4'd1, d); chk("R3 events after reset", d, 32'h0);
    rd(4'd2, d); chk("R2 mask after reset", d, 32'h0);
    chk("R2 irq after reset", {31'b0, irq_o}, 32'h0);
    chk("R8 ptr_rst after reset", {31'b0, ptr_rst_o}, 32'h0);
    rd(4'd7, d); chk("R10 unmapped reads zero", d, 32'h0);
  endtask

  task automatic t_ctrl_rw;
    logic [31:0] d;
    wr(4'd0, 32'hFFFF_FFF6);
    chk("R8 no pulse on enable rise", {31'b0, ptr_rst_o}, 32'h0);
    chk("R1 en_o set", {31'b0, en_o}, 32'h1);
    chk("R1 pinmux_o set", {31'b0, pinmux_o}, 32'h1);
    rd(4'd0, d); chk("R1 reserved ctrl bits ignored", d, 32'h6);
  endtask

  task automatic t_enable_fall;
    wr(4'd0, 32'h4);
    chk("R8 en_o cleared by write", {31'b0, en_o}, 32'h0);
    chk("R8 ptr_rst on enable fall", {31'b0, ptr_rst_o}, 32'h1);
    @(negedge clk);
    chk("R8 ptr_rst one cycle only", {31'b0, ptr_rst_o}, 32'h0);
    wr(4'd0, 32'h0);
    chk("R8 no pulse when enable stays low", {31'b0, ptr_rst_o}, 32'h0);
  endtask

  task automatic t_events;
    logic [31:0] d;
    pulse(10'b10_0000_0001);
    rd(4'd1, d); chk("R3 masked events recorded", d, 32'h8040_0000);
    chk("R2 irq low with mask zero", {31'b0, irq_o}, 32'h0);
    wr(4'd2, 32'h0040_0000);
    chk("R2 irq high after mask", {31'b0, irq_o}, 32'h1);
    wr(4'd1, 32'h0000_0000);
    rd(4'd1, d); chk("R4 zero write keeps events", d, 32'h8040_0000);
    wr(4'd1, 32'h0040_0000);
    chk("R2 irq low after clear", {31'b0, irq_o}, 32'h0);
    rd(4'd1, d); chk("R4 w1c clears one bit", d, 32'h8000_0000);
    pulse(10'h3FF);
    rd(4'd1, d); chk("R3 all events, reserved zero", d, 32'hFFC0_0000);
    wr(4'd1, 32'hFFFF_FFFF);
    rd(4'd1, d); chk("R4 clear all", d, 32'h0);
    wr(4'd2, 32'h0);
  endtask

  task automatic t_set_wins;
    logic [31:0] d;
    pulse(10'b00_0000_1000);
    @(negedge clk);
    evt_pulse = 10'b00_0000_1000;
    bus_we = 1'b1; bus_addr = 4'd1; bus_wdata = 32'h1000_0000;
    @(negedge clk);
    evt_pulse = '0; bus_we = 1'b0;
    rd(4'd1, d); chk("R5 event beats clear", d, 32'h1000_0000);
    wr(4'd1, 32'h1000_0000);
    rd(4'd1, d); chk("R4 cleared after race", d, 32'h0);
  endtask

  task automatic t_local_reset;
    logic [31:0] d;
    int ones;
    wr(4'd0, 32'h2);
    wr(4'd2, 32'hFFC0_0000);
    pulse(10'b00_0000_0010);
    chk("R2 irq before local reset", {31'b0, irq_o}, 32'h1);
    wr(4'd0, 32'h3);
    chk("R8 ptr_rst on local reset", {31'b0, ptr_rst_o}, 32'h1);
    chk("R6 en_o cleared by local reset", {31'b0, en_o}, 32'h0);
    ones = 0;
    for (int i = 0; i < 24; i++) begin
      @(negedge clk);
      if (bus_rdata[0]) ones++;
    end
    chk("R6 reset bit high for 16 cycles", ones, 32'd16);
    rd(4'd1, d); chk("R6 events cleared", d, 32'h0);
    rd(4'd2, d); chk("R6 mask cleared", d, 32'h0);
    chk("R6 irq low after local reset", {31'b0, irq_o}, 32'h0);
  endtask

  task automatic t_busy_ignores;
    logic [31:0] d;
    wr(4'd0, 32'h1);
    wr(4'd2, 32'hFFC0_0000);
    pulse(10'h3FF);
    wr(4'd0, 32'h6);
    wr(4'd1, 32'h0);
    repeat (20) @(negedge clk);
    rd(4'd2, d); chk("R7 mask write ignored in reset", d, 32'h0);
    rd(4'd0, d); chk("R7 ctrl write ignored in reset", d, 32'h0);
    rd(4'd1, d); chk("R9 pulses ignored in reset", d, 32'h0);
    chk("R7 en_o stays low", {31'b0, en_o}, 32'h0);
    wr(4'd0, 32'h2);
    chk("R1 writes accepted after reset", {31'b0, en_o}, 32'h1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    t_reset_state();
    t_ctrl_rw();
    t_enable_fall();
    t_events();
    t_set_wins();
    t_local_reset();
    t_busy_ignores();
    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog actual=timeout expected=done");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end
endmodule